// File: doc/BRIEF.md
# Quadrature Position Counter with Cascade Outputs

The block tracks the position of an incremental encoder from its two quadrature channels. Both channels are resynchronised to the system clock. Every legal edge on either channel moves a binary up/down position counter by one, which gives four counts per encoder line. The counter width is a parameter, 12 or 16 bits.

Each counted edge is also reported on a one-cycle step strobe with a direction level. This lets downstream logic follow individual counts without reading the full position. When the counter wraps past either end of its range, a cascade pulse is produced together with a cascade direction level. An external counter clocked on the rising edge of that pulse can then hold the upper bits of a wider position.

Top module: `quad_cascade_counter`

## Requirements
- R1: While rst_ni is low, count_o is zero and step_o and casc_pulse_o are low. The channel levels present at or just after reset release never cause a count, whatever those levels are.
- R2: Channel state is written {A,B}. The forward cycle 00 -> 01 -> 11 -> 10 -> 00 adds one to count_o per transition. The reverse cycle subtracts one per transition. Both wrap modulo 2^CNT_W.
- R3: A transition that changes both channels at once (a jump of two states) leaves count_o unchanged and raises no step_o.
- R4: step_o is high for exactly one cycle per counted transition, in the cycle where count_o shows the new value. dir_up_o is then 1 for an increment and 0 for a decrement, and it holds that value until the next count.
- R5: A channel change that is held for at least one clock reaches count_o after three rising clock edges: two synchroniser stages and the counter register.
- R6: Incrementing from all ones gives zero. In the cycle where count_o first reads zero, casc_pulse_o is high during the clock-high half and casc_up_o is 1.
- R7: Decrementing from zero gives all ones. In that cycle casc_pulse_o is high during the clock-high half and casc_up_o is 0.
- R8: casc_pulse_o is low during every clock-low half. It pulses only in cycles that follow a wrap.
- R9: CNT_W selects the counter width (12 or 16). Wrap points are 2^CNT_W-1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_a_i | input | 1 | Quadrature channel A, asynchronous |
| chan_b_i | input | 1 | Quadrature channel B, asynchronous |
| count_o | output | CNT_W | Position counter |
| step_o | output | 1 | One-cycle strobe per counted transition |
| dir_up_o | output | 1 | Direction of last count, 1 = up |
| casc_pulse_o | output | 1 | Half-cycle pulse on wrap |
| casc_up_o | output | 1 | Direction of last wrap, 1 = overflow |

## Verification
The assertions assume that each channel level is held for at least one full clock cycle. Only then does every change reach the decoder as a single-state or double-state step, so the counter moves by at most one per cycle. The bench drives the channels only on falling clock edges, holds each value for one to three cycles, and waits for the post-reset priming window to pass before it moves them. Random walks start near zero so that both wrap directions occur. Directed steps cover the exact latency and the wrap cycles.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // position of a {A,B} state along the forward Gray cycle
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_pos = 2'd0;
      2'b01:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= '0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/qdc_decode.sv
module qdc_decode
  import qdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ab_i,
  output step_e      step_o
);
  localparam int ARM_AT = SYNC_STAGES + 1;
  localparam int PW     = $clog2(ARM_AT + 1);

  logic [1:0]    prev_q;
  logic [PW-1:0] prime_q;
  logic          armed;
  logic [1:0]    delta;

  // hold off until the synchroniser and prev register carry real levels
  assign armed = (prime_q == PW'(ARM_AT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      prev_q <= ab_i;
      if (!armed) prime_q <= prime_q + 1'b1;
    end
  end

  assign delta = gray_pos(ab_i) - gray_pos(prev_q);

  always_comb begin
    step_o = STEP_NONE;
    if (armed) begin
      case (delta)
        2'd1:    step_o = STEP_UP;
        2'd3:    step_o = STEP_DN;
        2'd2:    step_o = STEP_BAD;
        default: step_o = STEP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/qdc_counter.sv
module qdc_counter
  import qdc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_e            step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             step_o,
  output logic             dir_up_o,
  output logic             wrap_o,
  output logic             wrap_up_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             step_q, dir_q, wrap_q, wrap_up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      step_q    <= 1'b0;
      dir_q     <= 1'b0;
      wrap_q    <= 1'b0;
      wrap_up_q <= 1'b0;
    end else begin
      step_q <= 1'b0;
      wrap_q <= 1'b0;
      case (step_i)
        STEP_UP: begin
          cnt_q  <= cnt_q + 1'b1;
          step_q <= 1'b1;
          dir_q  <= 1'b1;
          if (cnt_q == CNT_MAX) begin
            wrap_q    <= 1'b1;
            wrap_up_q <= 1'b1;
          end
        end
        STEP_DN: begin
          cnt_q  <= cnt_q - 1'b1;
          step_q <= 1'b1;
          dir_q  <= 1'b0;
          if (cnt_q == '0) begin
            wrap_q    <= 1'b1;
            wrap_up_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign count_o   = cnt_q;
  assign step_o    = step_q;
  assign dir_up_o  = dir_q;
  assign wrap_o    = wrap_q;
  assign wrap_up_o = wrap_up_q;
endmodule

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter
  import qdc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_a_i,
  input  logic             chan_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic             step_o,
  output logic             dir_up_o,
  output logic             casc_pulse_o,
  output logic             casc_up_o
);
  logic [1:0] ab_sync;
  step_e      step;
  logic       casc_en;

  qdc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({chan_a_i, chan_b_i}),
    .q_o    (ab_sync)
  );

  qdc_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ab_i   (ab_sync),
    .step_o (step)
  );

  qdc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .count_o   (count_o),
    .step_o    (step_o),
    .dir_up_o  (dir_up_o),
    .wrap_o    (casc_en),
    .wrap_up_o (casc_up_o)
  );

  // registered enable gated by clock level: pulse covers the high half only
  assign casc_pulse_o = casc_en & clk_i;
endmodule

// File: rtl/qdc_checker.sv
module qdc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic             step_o,
  input logic             dir_up_o,
  input logic             casc_up_o,
  input logic             casc_en_i
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAXV = '1;

  p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> (count_o == $past(count_o) + ONE) || (count_o == $past(count_o) - ONE));

  p_strobe_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (count_o != $past(count_o)));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |-> $stable(count_o));

  p_dir_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && dir_up_o) |-> (count_o == $past(count_o) + ONE));

  p_wrap_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && dir_up_o && count_o == '0) |-> (casc_en_i && casc_up_o));

  p_wrap_dn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !dir_up_o && count_o == MAXV) |-> (casc_en_i && !casc_up_o));

  p_casc_only_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_en_i |-> (step_o && (dir_up_o ? count_o == '0 : count_o == MAXV)));
endmodule

bind quad_cascade_counter qdc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_o   (count_o),
  .step_o    (step_o),
  .dir_up_o  (dir_up_o),
  .casc_up_o (casc_up_o),
  .casc_en_i (casc_en)
);

// File: tb/sim_quad_cascade_counter.sv
`timescale 1ns/1ps
module sim_quad_cascade_counter;
  localparam int CNT_W = 12;
  localparam int MOD   = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic [CNT_W-1:0] count;
  logic step, dir_up, casc_pulse, casc_up;

  int n_chk = 0, n_fail = 0;
  int gpos = 0;
  int exp_cnt = 0;
  int exp_su = 0, exp_sd = 0, exp_cu = 0, exp_cd = 0;
  int mon_su = 0, mon_sd = 0, mon_cu = 0, mon_cd = 0, mon_low = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_cascade_counter #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_a_i(a), .chan_b_i(b),
    .count_o(count), .step_o(step), .dir_up_o(dir_up),
    .casc_pulse_o(casc_pulse), .casc_up_o(casc_up)
  );

  function automatic logic [1:0] ab_of(input int p);
    case (p & 3)
      0: ab_of = 2'b00;
      1: ab_of = 2'b01;
      2: ab_of = 2'b11;
      default: ab_of = 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mid-high and mid-low sampling
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (step) begin if (dir_up) mon_su++; else mon_sd++; end
      if (casc_pulse) begin if (casc_up) mon_cu++; else mon_cd++; end
    end
    #10;
    if (casc_pulse) mon_low++;
  end

  // d: +1 forward, -1 reverse, 2 double jump, 0 none
  task automatic move(input int d, input int hold);
    @(negedge clk);
    if (d == 1 || d == -1) begin
      gpos = (gpos + d + 4) & 3;
      if (d == 1) begin
        exp_su++;
        if (exp_cnt == MOD - 1) exp_cu++;
        exp_cnt = (exp_cnt + 1) % MOD;
      end else begin
        exp_sd++;
        if (exp_cnt == 0) exp_cd++;
        exp_cnt = (exp_cnt + MOD - 1) % MOD;
      end
    end else if (d == 2) begin
      gpos = (gpos + 2) & 3;
    end
    {a, b} = ab_of(gpos);
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic settle_check(input string tag);
    repeat (5) @(negedge clk);
    check({tag, " count"}, int'(count), exp_cnt);
    check({tag, " up steps"}, mon_su, exp_su);
    check({tag, " down steps"}, mon_sd, exp_sd);
    check({tag, " up wraps"}, mon_cu, exp_cu);
    check({tag, " down wraps"}, mon_cd, exp_cd);
  endtask

  task automatic finish_run();
    check("R8 pulse in low half", mon_low, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with channels at 11 (Gray position 2)
    gpos = 2;
    {a, b} = ab_of(gpos);
    repeat (3) @(negedge clk);
    check("R1 reset count", int'(count), 0);
    check("R1 reset step", int'(step), 0);
    check("R1 reset casc", int'(casc_pulse), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 no count from reset levels", int'(count), 0);
    check("R1 no step from reset levels", mon_su + mon_sd, 0);

    // R5: exact latency of one forward step
    @(negedge clk);
    gpos = 3; {a, b} = ab_of(gpos);
    exp_su++; exp_cnt = 1;
    @(posedge clk); @(posedge clk); #5;
    check("R5 before third edge", int'(count), 0);
    @(posedge clk); #5;
    check("R5 after third edge", int'(count), 1);
    check("R4 strobe high", int'(step), 1);
    check("R4 dir up", int'(dir_up), 1);
    @(posedge clk); #5;
    check("R4 strobe one cycle", int'(step), 0);
    check("R4 dir held", int'(dir_up), 1);

    // R2: full forward then reverse cycles
    for (int i = 0; i < 8; i++) move(1, 1);
    settle_check("R2 forward");
    for (int i = 0; i < 5; i++) move(-1, 2);
    settle_check("R2 reverse");
    check("R4 dir down held", int'(dir_up), 0);

    // R3: double jumps ignored
    move(2, 2); move(2, 1);
    settle_check("R3 jump");

    // R7: walk down to zero then below
    while (exp_cnt != 0) move(-1, 1);
    @(negedge clk);
    gpos = (gpos + 3) & 3; {a, b} = ab_of(gpos);
    exp_sd++; exp_cd++; exp_cnt = MOD - 1;
    repeat (3) @(posedge clk); #5;
    check("R7 wrap value", int'(count), MOD - 1);
    check("R7 pulse high half", int'(casc_pulse), 1);
    check("R7 casc dir", int'(casc_up), 0);
    #10;
    check("R8 pulse low half", int'(casc_pulse), 0);

    // R6 / R9: step up from all ones
    @(negedge clk);
    gpos = (gpos + 1) & 3; {a, b} = ab_of(gpos);
    exp_su++; exp_cu++; exp_cnt = 0;
    repeat (3) @(posedge clk); #5;
    check("R6 wrap value", int'(count), 0);
    check("R6 pulse high half", int'(casc_pulse), 1);
    check("R6 casc dir", int'(casc_up), 1);
    @(posedge clk); #5;
    check("R8 no pulse after wrap", int'(casc_pulse), 0);
    settle_check("R9 wraps");

    // random walk around zero
    for (int i = 0; i < 600; i++) begin
      int r;
      int d;
      r = $urandom_range(0, 9);
      d = (r < 4) ? 1 : (r < 8) ? -1 : (r == 8) ? 2 : 0;
      move(d, $urandom_range(1, 3));
      if (i % 100 == 99) settle_check("R2 random");
    end
    settle_check("R8 random end");
    done = 1'b1;
    finish_run();
  end
endmodule